// File: doc/BRIEF.md
# Glial Routing Cell

This block is one tile of a two-dimensional routing fabric for spiking neuron networks. Each tile touches four neighbours (north, south, west, east). On every side it receives one axon spike line and one dendritic serial line, and it drives one of each back out. Every output is a registered many-to-one switch. An axon output can take any of the four axon inputs. A dendrite output can take any of the four dendrite inputs, or the output of a small local synapse. Because each hop adds exactly one register, the path length of a route sets its delay in clock cycles.

The local synapse is a bit-serial adder. Its dendritic input and its spike input each come from their own four-way selector. When a spike arrives on the chosen axon, the synapse adds a signed weight to the next packet that passes on the chosen dendrite. The packet is sent least significant bit first. A synapse is spliced into a passing loop in three rewiring steps, and it is removed by the same steps in reverse. All switch selections and the weight are held in a configuration bank. The bank is written one field at a time through an addressed write port, and the fabric controller uses this port to grow or prune routes at run time.

Top module: `glia_route_cell`

## Requirements
- R1: While reset is held, all outputs are 0. After reset, every output forwards the input on the opposite side (N↔S, W↔E) with one cycle of delay, for both axon and dendrite lines.
- R2: Address 4+s (s: 0=N, 1=S, 2=W, 3=E) holds a 2-bit code for axon output s. Code k makes that output equal axon input k one cycle later.
- R3: Address s holds a 3-bit code for dendrite output s. Codes 0 to 3 make that output equal dendrite input k one cycle later.
- R4: Dendrite code 4 selects the synapse output. Codes 5, 6 and 7 drive the output to 0.
- R5: A write updates its field at the clock edge where the write enable is sampled. The output register captures inputs under the new selection from the next edge on.
- R6: Writes to addresses 11 to 15 change no selection and no weight.
- R7: Address 8 selects the synapse's dendritic input and address 9 selects its spike axon, using the same side codes. Address 10 holds the weight. With no spike, the synapse passes its dendritic input through unchanged.
- R8: Frames are PKT_W cycles long, and the first frame starts in the first cycle after reset is released. A spike on the chosen axon in any cycle of a frame makes the next frame's packet, sent LSB first, come out as (packet + weight) mod 2^PKT_W. Several spikes in one frame add the weight only once, and the frame after that is unchanged.
- R9: Spikes on axon inputs that the synapse has not selected have no effect on the packet.
- R10: The dendrite data on a loop is bit-identical after each of the three formation steps and each of the three elimination steps, as long as no spike arrives.
- R11: Four different axons can be routed through the cell at once, each to its own output, with no interaction between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration field address |
| cfg_wdata | input | PKT_W | Configuration write data (low bits used for codes) |
| ax_in | input | 4 | Axon spike inputs, bit 0=N, 1=S, 2=W, 3=E |
| den_in | input | 4 | Dendrite serial inputs, same bit order |
| ax_out | output | 4 | Registered axon outputs |
| den_out | output | 4 | Registered dendrite outputs |

## Verification
The hardest case to reach from the ports is an addition lined up with the frame. The spike has to fall in the frame before the packet, and the packet bits have to arrive at frame phase 0 to PKT_W-1. The bench follows the frame phase with its own cycle counter from the moment reset is released. It then places spikes at the first phase, the last phase, and at two phases within one frame. The packets it uses are the corner values 0 and all-ones plus random ones, and the weights include +1, -1, the largest positive value, the most negative value and random values. The switch sweeps step through every code on every output, with random stimulus, and they keep the synapse's spike line quiet so that it cannot disturb the routing checks.

// File: rtl/glia_pkg.sv
// Shared constants and helpers for the glial routing cell.
// Side numbering is fixed: 0=N, 1=S, 2=W, 3=E; the opposite side is index^1.
package glia_pkg;
    localparam int SIDES  = 4;
    localparam int ASEL_W = $clog2(SIDES);
    localparam int DSEL_W = $clog2(SIDES + 1);
    localparam int ADDR_W = 4;

    // field addresses in the configuration bank
    localparam int ADDR_DEN_BASE = 0;
    localparam int ADDR_AX_BASE  = 4;
    localparam int ADDR_SYN_DEN  = 8;
    localparam int ADDR_SYN_AX   = 9;
    localparam int ADDR_WEIGHT   = 10;

    // dendritic code that picks the synapse output
    localparam logic [DSEL_W-1:0] DSEL_SYN = DSEL_W'(SIDES);

    // side across the cell from side s
    function automatic logic [ASEL_W-1:0] opposite(input int s);
        return ASEL_W'(s ^ 1);
    endfunction
endpackage

// File: rtl/glia_cfg_regs.sv
// Configuration bank of the routing cell.
// One field is written per cycle, selected by addr; a write lands at the
// sampling edge. Assumes addresses above ADDR_WEIGHT are unused and ignored.
module glia_cfg_regs
    import glia_pkg::*;
#(
    parameter int PKT_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [PKT_W-1:0]               wdata,
    output logic [SIDES-1:0][DSEL_W-1:0]   den_sel,
    output logic [SIDES-1:0][ASEL_W-1:0]   ax_sel,
    output logic [ASEL_W-1:0]              syn_den_sel,
    output logic [ASEL_W-1:0]              syn_ax_sel,
    output logic [PKT_W-1:0]               weight
);

    // output switch fields: reset to straight-through, then addressed writes
    always_ff @(posedge clk) begin
        for (int s = 0; s < SIDES; s++) begin
            if (!rst_n) begin
                den_sel[s] <= DSEL_W'(opposite(s));
                ax_sel[s]  <= opposite(s);
            end else if (we) begin
                if (addr == ADDR_W'(ADDR_DEN_BASE + s))
                    den_sel[s] <= wdata[DSEL_W-1:0];
                if (addr == ADDR_W'(ADDR_AX_BASE + s))
                    ax_sel[s] <= wdata[ASEL_W-1:0];
            end
        end
    end

    // synapse fields: input selectors and weight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            syn_den_sel <= '0;
            syn_ax_sel  <= '0;
            weight      <= '0;
        end else if (we) begin
            if (addr == ADDR_W'(ADDR_SYN_DEN)) syn_den_sel <= wdata[ASEL_W-1:0];
            if (addr == ADDR_W'(ADDR_SYN_AX))  syn_ax_sel  <= wdata[ASEL_W-1:0];
            if (addr == ADDR_W'(ADDR_WEIGHT))  weight      <= wdata;
        end
    end

    generate
        for (genvar s = 0; s < SIDES; s++) begin : g_chk
            AST_CFG_DEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                (we && addr == ADDR_W'(ADDR_DEN_BASE + s)) |=> den_sel[s] == $past(wdata[DSEL_W-1:0])); // R5
            AST_CFG_AX_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                (we && addr == ADDR_W'(ADDR_AX_BASE + s)) |=> ax_sel[s] == $past(wdata[ASEL_W-1:0])); // R5
        end
    endgenerate

    AST_CFG_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr > ADDR_W'(ADDR_WEIGHT)) |=>
        ($stable(den_sel) && $stable(ax_sel) && $stable(syn_den_sel)
         && $stable(syn_ax_sel) && $stable(weight))); // R6

endmodule

// File: rtl/glia_route_mux.sv
// Registered many-to-one switch: q takes d[sel] at each edge.
// Codes at or above N_IN select a constant 0. Assumes N_IN <= 2**SEL_W.
module glia_route_mux #(
    parameter int N_IN  = 4,
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   d,
    input  logic [SEL_W-1:0]  sel,
    output logic              q
);
    localparam int NPAD = 2 ** SEL_W;

    logic [NPAD-1:0] d_pad;

    // widen the input set so every code has a defined source
    generate
        if (N_IN < NPAD) begin : g_pad
            assign d_pad = {{(NPAD - N_IN){1'b0}}, d};
        end else begin : g_full
            assign d_pad = d;
        end
    endgenerate

    // pipeline register of the hop
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d_pad[sel];
    end
endmodule

// File: rtl/glia_serial_syn.sv
// Bit-serial synapse. A spike in one frame arms an addition of the weight
// to the packet of the following frame, LSB first, carry kept across bits.
// Assumes frames of PKT_W cycles aligned to reset release.
module glia_serial_syn #(
    parameter int PKT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             di,
    input  logic             spike,
    input  logic [PKT_W-1:0] weight,
    output logic             do_bit
);
    localparam int POS_W = (PKT_W > 1) ? $clog2(PKT_W) : 1;
    localparam logic [POS_W-1:0] LAST = POS_W'(PKT_W - 1);

    logic [POS_W-1:0] pos;
    logic             armed;
    logic             active;
    logic             carry;
    logic             w_bit;
    logic             sum;
    logic             cout;

    // full-adder slice on the current bit
    always_comb begin
        w_bit  = weight[pos];
        sum    = di ^ w_bit ^ carry;
        cout   = (di & w_bit) | (di & carry) | (w_bit & carry);
        do_bit = active ? sum : di;
    end

    // frame phase counter
    always_ff @(posedge clk) begin
        if (!rst_n)           pos <= '0;
        else if (pos == LAST) pos <= '0;
        else                  pos <= pos + 1'b1;
    end

    // arm on spike, start adding at the next frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            active <= 1'b0;
            carry  <= 1'b0;
        end else if (pos == LAST) begin
            active <= armed | spike;
            armed  <= 1'b0;
            carry  <= 1'b0;
        end else begin
            armed  <= armed | spike;
            carry  <= active & cout;
        end
    end

    AST_SYN_FRAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active) |-> pos == '0); // R8
    AST_SYN_FRESH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        pos == '0 |-> (!armed && !carry)); // R8
endmodule

// File: rtl/glia_route_cell.sv
// One glial routing tile: four registered axon switches, four registered
// dendrite switches with a synapse tap, and synapse input selectors, all
// steered by the configuration bank. Side bits: 0=N, 1=S, 2=W, 3=E.
module glia_route_cell
    import glia_pkg::*;
#(
    parameter int PKT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [3:0]         cfg_addr,
    input  logic [PKT_W-1:0]   cfg_wdata,
    input  logic [3:0]         ax_in,
    input  logic [3:0]         den_in,
    output logic [3:0]         ax_out,
    output logic [3:0]         den_out
);
    logic [SIDES-1:0][DSEL_W-1:0] den_sel;
    logic [SIDES-1:0][ASEL_W-1:0] ax_sel;
    logic [ASEL_W-1:0]            syn_den_sel;
    logic [ASEL_W-1:0]            syn_ax_sel;
    logic [PKT_W-1:0]             weight;
    logic                         syn_di;
    logic                         syn_spike;
    logic                         syn_do;
    logic [SIDES:0]               den_src;

    glia_cfg_regs #(.PKT_W(PKT_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .den_sel(den_sel), .ax_sel(ax_sel), .syn_den_sel(syn_den_sel),
        .syn_ax_sel(syn_ax_sel), .weight(weight)
    );

    // synapse input selectors and dendrite source set
    always_comb begin
        syn_di    = den_in[syn_den_sel];
        syn_spike = ax_in[syn_ax_sel];
        den_src   = {syn_do, den_in};
    end

    glia_serial_syn #(.PKT_W(PKT_W)) syn_i (
        .clk(clk), .rst_n(rst_n), .di(syn_di), .spike(syn_spike),
        .weight(weight), .do_bit(syn_do)
    );

    generate
        for (genvar s = 0; s < SIDES; s++) begin : g_side
            glia_route_mux #(.N_IN(SIDES), .SEL_W(ASEL_W)) ax_mux_i (
                .clk(clk), .rst_n(rst_n), .d(ax_in), .sel(ax_sel[s]), .q(ax_out[s])
            );
            glia_route_mux #(.N_IN(SIDES + 1), .SEL_W(DSEL_W)) den_mux_i (
                .clk(clk), .rst_n(rst_n), .d(den_src), .sel(den_sel[s]), .q(den_out[s])
            );

            AST_AX_HOP: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> ax_out[s] == $past(ax_in[ax_sel[s]])); // R2
            AST_DEN_HOP: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(den_sel[s]) < DSEL_SYN)
                |-> den_out[s] == $past(den_in[den_sel[s][ASEL_W-1:0]])); // R3
            AST_DEN_SYN_TAP: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(den_sel[s]) == DSEL_SYN)
                |-> den_out[s] == $past(syn_do)); // R4
            AST_DEN_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(den_sel[s]) > DSEL_SYN) |-> !den_out[s]); // R4
        end
    endgenerate
endmodule

// File: tb/glia_route_cell_tb_top.sv
module glia_route_cell_tb_top;
    localparam int P = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [3:0]   cfg_addr = '0;
    logic [P-1:0] cfg_wdata = '0;
    logic [3:0]   ax_in = '0;
    logic [3:0]   den_in = '0;
    logic [3:0]   ax_out;
    logic [3:0]   den_out;

    int total = 0;
    int bad = 0;
    int ph = 0;
    int dsel [4];
    int asel [4];
    int ssel_d = 0;
    int ssel_a = 0;

    glia_route_cell #(.PKT_W(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ax_in(ax_in), .den_in(den_in),
        .ax_out(ax_out), .den_out(den_out)
    );

    always #4 clk = ~clk;

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run hung act=running exp=finished");
        summary();
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        ph = (ph + 1) % P;
    endtask

    task automatic cfg_write(input int addr, input int data);
        cfg_we = 1'b1;
        cfg_addr = 4'(addr);
        cfg_wdata = P'(data);
        step();
        cfg_we = 1'b0;
        if (addr < 4) dsel[addr] = data & 7;
        else if (addr < 8) asel[addr-4] = data & 3;
        else if (addr == 8) ssel_d = data & 3;
        else if (addr == 9) ssel_a = data & 3;
    endtask

    // random stimulus on all lines, synapse spike line kept quiet
    task automatic check_route(input string req, input int cycles);
        for (int c = 0; c < cycles; c++) begin
            logic [3:0] din;
            logic [3:0] ain;
            din = 4'($urandom);
            ain = 4'($urandom) & ~(4'b1 << ssel_a);
            den_in = din;
            ax_in = ain;
            step();
            for (int s = 0; s < 4; s++) begin
                logic e;
                e = (dsel[s] < 4) ? din[dsel[s]] : ((dsel[s] == 4) ? din[ssel_d] : 1'b0);
                chk($sformatf("%s den_out[%0d] sel=%0d", req, s, dsel[s]), 32'(den_out[s]), 32'(e));
                chk($sformatf("%s ax_out[%0d] sel=%0d", req, s, asel[s]), 32'(ax_out[s]), 32'(ain[asel[s]]));
            end
        end
    endtask

    // synapse at frame level: spikes in one frame, packet on next frame
    task automatic syn_packet(input string req, input int w, input logic [P-1:0] pkt,
                              input int spk_side, input int ph_a, input int ph_b,
                              input logic [P-1:0] exp);
        logic [P-1:0] got;
        cfg_write(10, w);
        den_in = '0;
        ax_in = '0;
        while (ph != 0) step();
        for (int c = 0; c < P; c++) begin
            ax_in = (spk_side >= 0 && (c == ph_a || c == ph_b)) ? (4'b1 << spk_side) : 4'b0;
            step();
        end
        ax_in = '0;
        for (int b = 0; b < P; b++) begin
            den_in[ssel_d] = pkt[b];
            step();
            got[b] = den_out[1];
        end
        den_in = '0;
        chk($sformatf("%s w=%0h pkt=%0h", req, w, pkt), 32'(got), 32'(exp));
    endtask

    initial begin
        for (int s = 0; s < 4; s++) begin
            dsel[s] = s ^ 1;
            asel[s] = s ^ 1;
        end
        den_in = 4'hF;
        ax_in = 4'hE;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero during reset
        chk("R1 reset den_out", 32'(den_out), 32'h0);
        chk("R1 reset ax_out", 32'(ax_out), 32'h0);
        rst_n = 1'b1;
        ph = 0;
        check_route("R1 straight-through", 8);

        // R2 / R3 / R4 sweep over every code of every output
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 4; k++) begin
                cfg_write(4 + s, k);
                check_route("R2", 3);
            end
            cfg_write(4 + s, s ^ 1);
            for (int k = 0; k < 8; k++) begin
                cfg_write(s, k);
                check_route(k < 4 ? "R3" : "R4", 3);
            end
            cfg_write(s, s ^ 1);
        end

        // R5: exact edge where a new selection applies
        den_in = 4'b0010;            // S=1, W=0
        cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = P'(2);
        step();
        cfg_we = 1'b0; dsel[0] = 2;
        chk("R5 write cycle uses old selection", 32'(den_out[0]), 32'h1);
        den_in = 4'b0100;            // S=0, W=1
        step();
        chk("R5 next cycle uses new selection", 32'(den_out[0]), 32'h1);
        den_in = 4'b0010;
        step();
        chk("R5 new selection ignores S", 32'(den_out[0]), 32'h0);
        cfg_write(0, 1);

        // R6: unused addresses leave all fields alone
        for (int a = 11; a < 16; a++) begin
            cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = P'(7);
            step();
        end
        cfg_we = 1'b0;
        check_route("R6 routing kept", 4);

        // R11: four axons permuted through the cell at once
        cfg_write(4, 3); cfg_write(5, 2); cfg_write(6, 0); cfg_write(7, 1);
        check_route("R11", 8);
        for (int s = 0; s < 4; s++) cfg_write(4 + s, s ^ 1);

        // R10: formation on the N->S loop, data checked after each step
        cfg_write(9, 2);   check_route("R10 form step1", 4);
        cfg_write(8, dsel[1]); check_route("R10 form step2", 4);
        cfg_write(1, 4);   check_route("R10 form step3", 4);

        // R7: idle synapse passes packets
        syn_packet("R7 idle", 8'h35, 8'hA5, -1, 0, 0, 8'hA5);

        // R8: additions across weight and packet corners
        begin
            int ws [6];
            logic [P-1:0] ps [3];
            ws[0] = 1; ws[1] = 8'hFF; ws[2] = 8'h7F; ws[3] = 8'h80;
            ws[4] = int'($urandom) & 8'hFF; ws[5] = 8'h5A;
            ps[0] = 8'h00; ps[1] = 8'hFF; ps[2] = 8'($urandom);
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 3; j++)
                    syn_packet("R8 add", ws[i], ps[j], 2, 0, 0, P'(ps[j] + P'(ws[i])));
        end
        syn_packet("R8 spike at last phase", 8'h11, 8'h0F, 2, P - 1, P - 1, 8'h20);
        syn_packet("R8 two spikes add once", 8'h03, 8'h10, 2, 1, 4, 8'h13);
        syn_packet("R8 following frame clean", 8'h03, 8'h10, -1, 0, 0, 8'h10);

        // R9: spikes on unselected axons
        for (int s = 0; s < 4; s++)
            if (s != 2) syn_packet("R9 other axon", 8'h44, 8'h21, s, 0, 3, 8'h21);

        // R10: elimination in reverse order
        cfg_write(1, 0);   check_route("R10 elim step1", 4);
        cfg_write(8, 0);   check_route("R10 elim step2", 4);
        cfg_write(9, 0);   check_route("R10 elim step3", 4);

        summary();
    end
endmodule